// File: doc/BRIEF.md
# Swept-Frequency PWM Gate Latch

This block is the digital timing core of a current-mode switching controller. A free-running period counter emits one start pulse per switching cycle. The counter's period is swept slowly up and down between two limits, which spreads the switching energy over a band of frequencies instead of a single line. Each start pulse sets a latch that drives the gate-enable output. The latch is cleared by the first of three comparator results: the PWM comparator, the soft-start comparator or the peak current comparator.

All three comparator inputs pass through two-flop synchronizers. The peak current input must also survive a spike filter, and it is ignored during a blanking window right after each turn-on. Clearing acts combinationally on the gate output, so the gate falls in the same cycle that the synchronized request appears. An undervoltage input, assumed synchronous to the clock, holds the gate low and suppresses set pulses. A two-bit code reports which source caused the most recent shutdown.

With the default parameters and a 100 MHz clock, the nominal period is about 1538 cycles (65 kHz) and the limits are 1479 and 1603 cycles (about ±2.6 kHz). One step of one cycle every 1613 clocks gives a full up-and-down sweep of about 4 ms. The blanking window is 22 cycles and the filter is 19 cycles.

Top module: `jitter_pwm_latch`

## Requirements
- R1: `cycle_start_o` is high for exactly one clock per switching cycle. The number of clocks between consecutive pulses always lies in [MIN_PERIOD, MAX_PERIOD], and the first interval after reset is MIN_PERIOD.
- R2: The target period moves by STEP_SIZE once every STEP_CYCLES clocks. It rises until it reaches MAX_PERIOD, then falls until it reaches MIN_PERIOD, and repeats (triangular sweep). A new period takes effect at the start of a switching cycle.
- R3: When no shutdown request is present and undervoltage is inactive, `gate_o` goes high in the clock after a `cycle_start_o` pulse and stays high until a shutdown.
- R4: A PWM or soft-start input held high is seen after two synchronizer flops. `gate_o` is low in the same cycle that the synchronized value is high, with no further register stage.
- R5: If a PWM or soft-start request is already active in the cycle of a start pulse, the latch is not set and `gate_o` stays low for that whole switching cycle.
- R6: A peak current request is accepted only after the synchronized input has been high for FILTER_CYCLES consecutive clocks. A shorter pulse has no effect on `gate_o`.
- R7: A peak current request is ignored in the start-pulse cycle and during the BLANK_CYCLES clocks after it. A request that is still present when the window ends shuts the gate off in the first cycle after the window.
- R8: While `uvlo_i` is high, `gate_o` is low in the same cycle, and start pulses do not set the latch. After `uvlo_i` falls, the gate stays low until the next start pulse.
- R9: `cause_o` is updated when a request clears an active latch or blocks a set. The codes are 0 none, 1 PWM, 2 soft start and 3 peak current. When requests coincide, peak current wins over soft start, and soft start wins over PWM.
- R10: During reset `gate_o` is 0 and `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| uvlo_i | input | 1 | Undervoltage lockout, synchronous to clk_i |
| pwm_cmp_i | input | 1 | PWM comparator result, asynchronous |
| ss_cmp_i | input | 1 | Soft-start comparator result, asynchronous |
| ilim_cmp_i | input | 1 | Peak current comparator result, asynchronous |
| gate_o | output | 1 | Gate enable |
| cycle_start_o | output | 1 | One-clock pulse at the start of each switching cycle |
| cause_o | output | 2 | Source of the last shutdown (0 none, 1 PWM, 2 soft start, 3 peak current) |

## Verification
The bench builds the block with MIN_PERIOD 20, MAX_PERIOD 28, a step of 1 every 10 clocks, BLANK_CYCLES 6 and FILTER_CYCLES 3. With these values a complete triangular sweep takes only 160 clocks, so both turning points and the bounds on the interval are observed many times. Every blanking edge, filter threshold and synchronizer delay also fits inside a single 20-clock switching cycle. This lets each shutdown case be placed at an exact clock offset from the start pulse, including the cycle just before the blanking window ends and the first cycle after it.

// File: rtl/jitter_pwm_latch.sv
module jitter_pwm_latch #(
  parameter int MIN_PERIOD    = 1479,
  parameter int MAX_PERIOD    = 1603,
  parameter int STEP_SIZE     = 1,
  parameter int STEP_CYCLES   = 1613,
  parameter int BLANK_CYCLES  = 22,
  parameter int FILTER_CYCLES = 19,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uvlo_i,
  input  logic       pwm_cmp_i,
  input  logic       ss_cmp_i,
  input  logic       ilim_cmp_i,
  output logic       gate_o,
  output logic       cycle_start_o,
  output logic [1:0] cause_o
);

  localparam int PW = $clog2(MAX_PERIOD + 1);
  localparam int SW = $clog2(STEP_CYCLES + 1);
  localparam int BW = $clog2(BLANK_CYCLES + 1);
  localparam int FW = $clog2(FILTER_CYCLES + 1);

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_PWM  = 2'd1;
  localparam logic [1:0] CAUSE_SS   = 2'd2;
  localparam logic [1:0] CAUSE_CL   = 2'd3;

  logic [2:0] sync_q [SYNC_STAGES];
  logic pwm_s, ss_s, ilim_s;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {ilim_cmp_i, ss_cmp_i, pwm_cmp_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pwm_s  = sync_q[SYNC_STAGES-1][0];
  assign ss_s   = sync_q[SYNC_STAGES-1][1];
  assign ilim_s = sync_q[SYNC_STAGES-1][2];

  logic [PW-1:0] phase_q, cur_per_q, tgt_per_q;
  logic [SW-1:0] step_q;
  logic          up_q;
  logic          at_end;

  assign at_end        = (phase_q == cur_per_q - PW'(1));
  assign cycle_start_o = (phase_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      cur_per_q <= PW'(MIN_PERIOD);
    end else if (at_end) begin
      phase_q   <= '0;
      cur_per_q <= tgt_per_q;
    end else begin
      phase_q   <= phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      step_q    <= '0;
      tgt_per_q <= PW'(MIN_PERIOD);
      up_q      <= 1'b1;
    end else if (step_q == SW'(STEP_CYCLES - 1)) begin
      step_q <= '0;
      if (up_q) begin
        if (int'(tgt_per_q) + STEP_SIZE >= MAX_PERIOD) begin
          tgt_per_q <= PW'(MAX_PERIOD);
          up_q      <= 1'b0;
        end else begin
          tgt_per_q <= tgt_per_q + PW'(STEP_SIZE);
        end
      end else begin
        if (int'(tgt_per_q) - STEP_SIZE <= MIN_PERIOD) begin
          tgt_per_q <= PW'(MIN_PERIOD);
          up_q      <= 1'b1;
        end else begin
          tgt_per_q <= tgt_per_q - PW'(STEP_SIZE);
        end
      end
    end else begin
      step_q <= step_q + SW'(1);
    end
  end

  logic [FW-1:0] run_q;
  logic          cl_qual;

  assign cl_qual = ilim_s && (run_q == FW'(FILTER_CYCLES - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !ilim_s) run_q <= '0;
    else if (!cl_qual)      run_q <= run_q + FW'(1);
  end

  logic [BW-1:0] blank_q;
  logic          blank_act, cl_req, rst_req, turn_on, gate_q;

  assign blank_act = cycle_start_o || (blank_q != '0);
  assign cl_req    = cl_qual && !blank_act;
  assign rst_req   = pwm_s || ss_s || cl_req;
  assign turn_on   = cycle_start_o && !uvlo_i && !rst_req;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)              blank_q <= '0;
    else if (turn_on)         blank_q <= BW'(BLANK_CYCLES);
    else if (blank_q != '0)   blank_q <= blank_q - BW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                gate_q <= 1'b0;
    else if (uvlo_i || rst_req) gate_q <= 1'b0;
    else if (cycle_start_o)     gate_q <= 1'b1;
  end

  assign gate_o = gate_q && !rst_req && !uvlo_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)
      cause_o <= CAUSE_NONE;
    else if ((gate_q || cycle_start_o) && rst_req)
      cause_o <= cl_req ? CAUSE_CL : (ss_s ? CAUSE_SS : CAUSE_PWM);
  end

endmodule

// File: rtl/jitter_pwm_latch_checker.sv
module jitter_pwm_latch_checker #(
  parameter int MIN_PERIOD    = 1479,
  parameter int MAX_PERIOD    = 1603,
  parameter int BLANK_CYCLES  = 22,
  parameter int FILTER_CYCLES = 19
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uvlo_i,
  input logic       gate_o,
  input logic       cycle_start_o,
  input logic [1:0] cause_o,
  input logic       pwm_s,
  input logic       ss_s,
  input logic       ilim_s
);
  localparam int CW = $clog2(MAX_PERIOD + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] gap_q, run_q;
  logic          seen_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cycle_start_o) begin
      gap_q  <= CW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != CMAX) begin
      gap_q  <= gap_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !ilim_s) run_q <= '0;
    else if (run_q != CMAX) run_q <= run_q + CW'(1);
  end

  p_start_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |=> !cycle_start_o);

  p_period_bounds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_o && seen_q) |-> (gap_q >= CW'(MIN_PERIOD) && gap_q <= CW'(MAX_PERIOD)));

  p_on_after_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(cycle_start_o));

  p_pwm_kill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_s |-> !gate_o);

  p_ss_kill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_s |-> !gate_o);

  p_reset_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_o && (pwm_s || ss_s)) |=> !gate_o);

  p_filter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_o) && !pwm_s && !ss_s && !uvlo_i) |-> (ilim_s && run_q >= CW'(FILTER_CYCLES - 1)));

  p_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_o) && !pwm_s && !ss_s && !uvlo_i) |-> (gap_q > CW'(BLANK_CYCLES)));

  p_uvlo_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> !gate_o);

  p_cause_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cause_o) |-> (cause_o != 2'd0));

  p_cause_pwm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cause_o) && cause_o == 2'd1) |-> $past(pwm_s));

endmodule

bind jitter_pwm_latch jitter_pwm_latch_checker #(
  .MIN_PERIOD(MIN_PERIOD),
  .MAX_PERIOD(MAX_PERIOD),
  .BLANK_CYCLES(BLANK_CYCLES),
  .FILTER_CYCLES(FILTER_CYCLES)
) u_checker (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .uvlo_i(uvlo_i),
  .gate_o(gate_o),
  .cycle_start_o(cycle_start_o),
  .cause_o(cause_o),
  .pwm_s(pwm_s),
  .ss_s(ss_s),
  .ilim_s(ilim_s)
);

// File: tb/jitter_pwm_latch_bench.sv
module jitter_pwm_latch_bench;
  localparam int MINP = 20;
  localparam int MAXP = 28;
  localparam int BLK  = 6;
  localparam int FLT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b0, pwm = 1'b0, ss = 1'b0, ilim = 1'b0;
  logic gate, start;
  logic [1:0] cause;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  jitter_pwm_latch #(
    .MIN_PERIOD(MINP), .MAX_PERIOD(MAXP), .STEP_SIZE(1), .STEP_CYCLES(10),
    .BLANK_CYCLES(BLK), .FILTER_CYCLES(FLT), .SYNC_STAGES(2)
  ) u_jitter_pwm_latch (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo),
    .pwm_cmp_i(pwm), .ss_cmp_i(ss), .ilim_cmp_i(ilim),
    .gate_o(gate), .cycle_start_o(start), .cause_o(cause)
  );

  // columns: source mask (1 pwm, 2 ss, 4 ilim), drive offset, length,
  // gate sample offset, expected gate, expected cause two clocks later, requirement
  localparam int NV = 10;
  localparam int TBL [NV][7] = '{
    '{1, 5, 2,  6, 1, 1, 4},  // R4 one clock before the kill
    '{1, 5, 2,  7, 0, 1, 4},  // R4 pwm kill
    '{2, 8, 2, 10, 0, 2, 4},  // R4 soft-start kill
    '{4, 1, 3,  8, 1, 2, 7},  // R7 request inside blanking ignored
    '{4, 8, 2, 14, 1, 2, 6},  // R6 spike shorter than filter
    '{4, 8, 4, 11, 1, 3, 6},  // R6 filter not yet met
    '{4, 8, 4, 12, 0, 3, 6},  // R6 filter met
    '{1, 5, 2,  7, 0, 1, 9},  // R9 pwm code
    '{4, 2, 6,  6, 1, 3, 7},  // R7 last blanked clock
    '{4, 2, 6,  7, 0, 3, 7}   // R7 first clock after blanking
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!start);
  endtask

  task automatic drive(input int mask, input logic v);
    if (mask[0]) pwm = v;
    if (mask[1]) ss = v;
    if (mask[2]) ilim = v;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 gate in reset", int'(gate), 0);
    check("R10 cause in reset", int'(cause), 0);
    @(negedge clk) rst_n = 1'b1;

    for (int e = 0; e < NV; e++) begin
      wait_start();
      for (int j = 1; j <= TBL[e][3] + 2; j++) begin
        @(negedge clk);
        if (j == TBL[e][3])
          check($sformatf("R%0d vector %0d gate", TBL[e][6], e), int'(gate), TBL[e][4]);
        if (j == TBL[e][3] + 2)
          check($sformatf("R%0d vector %0d cause", TBL[e][6], e), int'(cause), TBL[e][5]);
        if (j == TBL[e][1]) drive(TBL[e][0], 1'b1);
        if (j == TBL[e][1] + TBL[e][2]) drive(TBL[e][0], 1'b0);
      end
      drive(7, 1'b0);
    end

    // R5: pwm already active at the start pulse
    wait_start();
    repeat (15) @(negedge clk);
    pwm = 1'b1;
    wait_start();
    @(negedge clk);
    check("R5 set blocked", int'(gate), 0);
    pwm = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 stays low after release", int'(gate), 0);
    wait_start();
    @(negedge clk);
    check("R3 gate on after start", int'(gate), 1);

    // R7: peak current held across the start pulse
    wait_start();
    repeat (15) @(negedge clk);
    ilim = 1'b1;
    wait_start();
    @(negedge clk);
    check("R7 set proceeds despite request", int'(gate), 1);
    repeat (BLK - 1) @(negedge clk);
    check("R7 held through window", int'(gate), 1);
    @(negedge clk);
    check("R7 off after window", int'(gate), 0);
    ilim = 1'b0;
    @(negedge clk);
    check("R9 peak current code", int'(cause), 3);

    // R8: undervoltage
    wait_start();
    repeat (3) @(negedge clk);
    uvlo = 1'b1;
    #1;
    check("R8 gate low same cycle", int'(gate), 0);
    wait_start();
    @(negedge clk);
    check("R8 set ignored", int'(gate), 0);
    uvlo = 1'b0;
    @(negedge clk);
    check("R8 low after release", int'(gate), 0);
    wait_start();
    @(negedge clk);
    check("R8 recovers at next start", int'(gate), 1);

    // R9: soft start and peak current accepted in the same clock
    wait_start();
    repeat (5) @(negedge clk);
    pwm = 1'b1;
    repeat (2) @(negedge clk);
    pwm = 1'b0;
    @(negedge clk);
    check("R9 pwm code before priority case", int'(cause), 1);
    wait_start();
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      if (j == 12) check("R9 both requests kill gate", int'(gate), 0);
      if (j == 14) check("R9 peak current wins", int'(cause), 3);
      if (j == 8)  ilim = 1'b1;
      if (j == 10) ss = 1'b1;
      if (j == 12) begin ss = 1'b0; ilim = 1'b0; end
    end

    // R1 and R2: sweep of the switching interval
    begin
      int cnt, prev, lo, hi, bad, ups, downs, jump;
      prev = -1; lo = 1000; hi = 0; bad = 0; ups = 0; downs = 0; jump = 0;
      wait_start();
      for (int n = 0; n < 60; n++) begin
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!start);
        if (cnt < MINP || cnt > MAXP) bad++;
        if (cnt < lo) lo = cnt;
        if (cnt > hi) hi = cnt;
        if (prev >= 0) begin
          if (cnt > prev) ups++;
          if (cnt < prev) downs++;
          if (cnt - prev > 3 || prev - cnt > 3) jump++;
        end
        prev = cnt;
      end
      check("R1 intervals out of bounds", bad, 0);
      check("R2 reaches lower region", int'(lo <= MINP + 2), 1);
      check("R2 reaches upper region", int'(hi >= MAXP - 2), 1);
      check("R2 sweep rises", int'(ups > 0), 1);
      check("R2 sweep falls", int'(downs > 0), 1);
      check("R2 step size bounded", jump, 0);
    end

    // R1: first interval after a fresh reset
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 gate after reset", int'(gate), 0);
    check("R10 cause cleared", int'(cause), 0);
    rst_n = 1'b1;
    begin
      int cnt;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!start);
      check("R1 first interval", cnt, MINP);
    end

    finish_run();
  end
endmodule